// File: doc/BRIEF.md
# Parallel Absolute-Value and Store Unit

This block is the execute stage for one paired operation on a 32-bit DSP-style datapath. In a single clock it fetches a signed integer from memory, forms its two's-complement magnitude and writes the result to one of eight general registers. In the same clock it stores another general register to memory. Both memory addresses are indirect. Each is the value of a chosen auxiliary register plus a displacement. The displacement is zero, one, or one of two index registers.

Both halves of the pair work on a snapshot of the state at the start of the cycle. If the store names the register that the absolute-value half is writing, the store sends the old contents. If both halves point at the same memory word, the absolute-value half uses the word as it was before the store. The most negative input has no positive counterpart. For that input a mode bit selects whether the result saturates to the largest positive value or wraps back to the input. An overflow flag reports the case in either mode.

Instruction word layout:
- [31:26]: opcode, 110010 for this pair.
- [24:22]: register that receives the absolute value.
- [21:19]: register to store.
- [15:13]: auxiliary register for the load address.
- [12:11]: displacement mode for the load address.
- [7:5]: auxiliary register for the store address.
- [4:3]: displacement mode for the store address.

Displacement mode codes are 0 for +0, 1 for +1, 2 for +index0 and 3 for +index1. The remaining bits are ignored.

Top module: `abs_store_unit`

## Requirements
- R1: When an executed instruction reads a non-negative or ordinary negative source, the register named by bits [24:22] holds the magnitude of that source after the clock edge.
- R2: During an executed cycle, mem_we_o is high and mem_wdata_o carries the register named by bits [21:19], so memory is written at the same edge.
- R3: The load address is AR[bits 15:13] plus a displacement, and the store address is AR[bits 7:5] plus a displacement. The displacement is chosen by the 2-bit mode in bits 12:11 (load) or 4:3 (store): 0 adds 0, 1 adds 1, 2 adds index0, 3 adds index1.
- R4: If the stored register is the same register the absolute-value half writes, the value stored is the contents from before the cycle.
- R5: If the load and store addresses are equal, the absolute value is formed from the memory word as it was before the store, and the stored value ends up in memory.
- R6: A source of 80000000h yields 7FFFFFFFh when ovm_i is 1, and 80000000h when ovm_i is 0.
- R7: ovf_o is high in the cycle after an executed instruction whose source is 80000000h, in either mode. It is low in the cycle after any other cycle.
- R8: An instruction executes only when valid_i is 1 and bits [31:26] equal 110010. On any other cycle mem_we_o is low and no register changes.
- R9: While rst_ni is low, all eight registers and ovf_o are cleared.
- R10: The operation takes one clock. The results are visible immediately after the edge that ends the cycle in which the instruction was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| ar_i | input | 192 | Eight 24-bit auxiliary registers, AR0 in the low bits |
| ir0_i | input | 24 | Index register 0 |
| ir1_i | input | 24 | Index register 1 |
| ovm_i | input | 1 | Overflow mode: 1 saturates, 0 wraps |
| mem_raddr_o | output | 24 | Load address |
| mem_rdata_i | input | 32 | Load data, returned in the same cycle |
| mem_we_o | output | 1 | Store enable |
| mem_waddr_o | output | 24 | Store address |
| mem_wdata_o | output | 32 | Store data |
| ovf_o | output | 1 | Overflow seen on the previous executed instruction |
| rf_o | output | 256 | Contents of the eight general registers, R0 in the low bits |

## Verification
The absolute-value path is tried with these sources:
- small positive and small negative values, which separate a pass-through from a negation;
- zero and all-ones, which expose an off-by-one in the increment;
- the largest positive value and the value just above the most negative, which show whether the sign test is taken from the right bit;
- the most negative value under both overflow modes, which shows that the saturate and wrap choices and the flag are independent of each other.

Directed cases then cover the following:
- a store that reads the register being written, and a load and store at the same address, to separate snapshot ordering from write-through;
- each displacement mode, to show that the field decode and the index selection are correct;
- an invalid valid bit and a wrong opcode, to show that nothing is committed;
- a reset in the middle of a run.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam logic [5:0] ABS_ST_OPC = 6'b110010;

  typedef enum logic [1:0] {
    DISP_ZERO = 2'd0,
    DISP_ONE  = 2'd1,
    DISP_IX0  = 2'd2,
    DISP_IX1  = 2'd3
  } disp_e;

  typedef struct packed {
    logic [5:0] opc;
    logic       rsv_a;
    logic [2:0] abs_dst;
    logic [2:0] st_src;
    logic [2:0] rsv_b;
    logic [2:0] ld_ar;
    disp_e      ld_mode;
    logic [2:0] rsv_c;
    logic [2:0] st_ar;
    disp_e      st_mode;
    logic [2:0] rsv_d;
  } instr_t;
endpackage

// File: rtl/asu_agen.sv
module asu_agen #(
  parameter int ADDR_W = 24,
  parameter int NAR    = 8,
  localparam int SEL_W = $clog2(NAR)
) (
  input  logic [NAR*ADDR_W-1:0] ar_i,
  input  logic [ADDR_W-1:0]     ir0_i,
  input  logic [ADDR_W-1:0]     ir1_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  asu_pkg::disp_e        mode_i,
  output logic [ADDR_W-1:0]     addr_o
);
  logic [ADDR_W-1:0] base, disp;

  assign base = ar_i[sel_i*ADDR_W +: ADDR_W];

  always_comb begin
    unique case (mode_i)
      asu_pkg::DISP_ZERO: disp = '0;
      asu_pkg::DISP_ONE:  disp = ADDR_W'(1);
      asu_pkg::DISP_IX0:  disp = ir0_i;
      default:            disp = ir1_i;
    endcase
  end

  assign addr_o = base + disp;
endmodule

// File: rtl/asu_abs.sv
module asu_abs #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              ovm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] neg;
  assign neg   = ~src_i + DATA_W'(1);
  assign ovf_o = (src_i == MIN_NEG);

  always_comb begin
    if (ovf_o)                res_o = ovm_i ? MAX_POS : src_i;
    else if (src_i[DATA_W-1]) res_o = neg;
    else                      res_o = src_i;
  end
endmodule

// File: rtl/asu_regfile.sv
module asu_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SEL_W-1:0]       waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [NREG*DATA_W-1:0] rf_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (we_i && waddr_i == SEL_W'(g))  q <= wdata_i;
    end
    assign rf_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/abs_store_unit.sv
module abs_store_unit #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int NAR    = 8,
  parameter int ADDR_W = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [31:0]            instr_i,
  input  logic [NAR*ADDR_W-1:0]  ar_i,
  input  logic [ADDR_W-1:0]      ir0_i,
  input  logic [ADDR_W-1:0]      ir1_i,
  input  logic                   ovm_i,
  output logic [ADDR_W-1:0]      mem_raddr_o,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_waddr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  output logic                   ovf_o,
  output logic [NREG*DATA_W-1:0] rf_o
);
  asu_pkg::instr_t ins;
  logic exec, abs_ovf, ovf_q;
  logic [DATA_W-1:0] abs_res;
  logic unused_rsv;

  assign ins        = asu_pkg::instr_t'(instr_i);
  assign exec       = valid_i && (ins.opc == asu_pkg::ABS_ST_OPC);
  assign unused_rsv = ^{ins.rsv_a, ins.rsv_b, ins.rsv_c, ins.rsv_d};

  asu_agen #(.ADDR_W(ADDR_W), .NAR(NAR)) u_ld_agen (
    .ar_i(ar_i), .ir0_i(ir0_i), .ir1_i(ir1_i),
    .sel_i(ins.ld_ar), .mode_i(ins.ld_mode), .addr_o(mem_raddr_o)
  );

  asu_agen #(.ADDR_W(ADDR_W), .NAR(NAR)) u_st_agen (
    .ar_i(ar_i), .ir0_i(ir0_i), .ir1_i(ir1_i),
    .sel_i(ins.st_ar), .mode_i(ins.st_mode), .addr_o(mem_waddr_o)
  );

  asu_abs #(.DATA_W(DATA_W)) u_abs (
    .src_i(mem_rdata_i), .ovm_i(ovm_i), .res_o(abs_res), .ovf_o(abs_ovf)
  );

  asu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(exec),
    .waddr_i(ins.abs_dst), .wdata_i(abs_res), .rf_o(rf_o)
  );

  // store takes the pre-edge register value: snapshot semantics
  assign mem_wdata_o = rf_o[ins.st_src*DATA_W +: DATA_W];
  assign mem_we_o    = exec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= exec && abs_ovf;
  end
  assign ovf_o = ovf_q;
endmodule

// File: rtl/asu_chk.sv
module asu_chk #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int NAR    = 8,
  parameter int ADDR_W = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [31:0]            instr_i,
  input logic [NAR*ADDR_W-1:0]  ar_i,
  input logic [ADDR_W-1:0]      ir0_i,
  input logic [ADDR_W-1:0]      ir1_i,
  input logic                   ovm_i,
  input logic [ADDR_W-1:0]      mem_raddr_o,
  input logic [DATA_W-1:0]      mem_rdata_i,
  input logic                   mem_we_o,
  input logic [ADDR_W-1:0]      mem_waddr_o,
  input logic [DATA_W-1:0]      mem_wdata_o,
  input logic                   ovf_o,
  input logic [NREG*DATA_W-1:0] rf_o
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  function automatic logic [DATA_W-1:0] word_at(input logic [NREG*DATA_W-1:0] v,
                                                input logic [2:0] s);
    return v[s*DATA_W +: DATA_W];
  endfunction

  logic exec, hit_min;
  assign exec    = valid_i && (instr_i[31:26] == 6'b110010);
  assign hit_min = exec && (mem_rdata_i == MIN_NEG);

  // R8
  rf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> $stable(rf_o));
  // R8
  no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |-> !mem_we_o);
  // R2
  store_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec |-> mem_we_o);
  // R4
  store_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec |-> mem_wdata_o == word_at(rf_o, instr_i[21:19]));
  // R7
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_min |=> ovf_o);
  // R7
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_min |=> !ovf_o);
  // R6
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_min && ovm_i) |=> word_at(rf_o, $past(instr_i[24:22])) == MAX_POS);
  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_min && !ovm_i) |=> word_at(rf_o, $past(instr_i[24:22])) == MIN_NEG);
  // R1
  pos_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !mem_rdata_i[DATA_W-1]) |=> word_at(rf_o, $past(instr_i[24:22])) == $past(mem_rdata_i));
endmodule

bind abs_store_unit asu_chk #(.DATA_W(DATA_W), .NREG(NREG), .NAR(NAR), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_abs_store_unit.sv
module sim_abs_store_unit;
  localparam int DW = 32, AW = 24, NR = 8, NA = 8;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, ovm = 1'b0;
  logic [31:0] instr = '0;
  logic [NA*AW-1:0] ar = '0;
  logic [AW-1:0] ir0 = '0, ir1 = '0;
  logic [AW-1:0] raddr, waddr;
  logic [DW-1:0] rdata, wdata;
  logic we, ovf;
  logic [NR*DW-1:0] rf;
  logic [DW-1:0] mem [16];

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  assign rdata = mem[raddr[3:0]];
  always @(posedge clk) if (we) mem[waddr[3:0]] <= wdata;

  abs_store_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .ar_i(ar),
    .ir0_i(ir0), .ir1_i(ir1), .ovm_i(ovm), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata), .ovf_o(ovf), .rf_o(rf)
  );

  // {source, expected, ovm, expected ovf}
  localparam logic [65:0] VEC [8] = '{
    {32'h0000_0005, 32'h0000_0005, 1'b0, 1'b0},
    {32'hFFFF_FFFB, 32'h0000_0005, 1'b0, 1'b0},
    {32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0},
    {32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 1'b0},
    {32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [2:0] dst, input logic [2:0] ssrc,
                                     input logic [2:0] lar, input logic [1:0] lmd,
                                     input logic [2:0] sar, input logic [1:0] smd);
    logic [31:0] w = '0;
    w[31:26] = 6'b110010; w[24:22] = dst; w[21:19] = ssrc;
    w[15:13] = lar; w[12:11] = lmd; w[7:5] = sar; w[4:3] = smd;
    return w;
  endfunction

  function automatic logic [31:0] reg_of(input int k);
    return rf[k*DW +: DW];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_ar(input int k, input logic [AW-1:0] v);
    ar[k*AW +: AW] = v;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    set_ar(0, 24'd2); set_ar(1, 24'd8); set_ar(2, 24'd4);
    ir0 = 24'd3; ir1 = 24'd5;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    for (int k = 0; k < NR; k++) chk("R9", "reg after reset", reg_of(k), 32'h0);
    chk("R9", "ovf after reset", {31'b0, ovf}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // vector table: load from AR0+0=2, store R7 to AR1+1=9
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mem[2] = VEC[i][65:34];
      ovm = VEC[i][1];
      instr = mk(3'(i), 3'd7, 3'd0, 2'd0, 3'd1, 2'd1);
      valid = 1'b1;
      #1;
      chk("R3", "load addr +0", {8'b0, raddr}, 32'd2);
      chk("R3", "store addr +1", {8'b0, waddr}, 32'd9);
      chk("R2", "store enable", {31'b0, we}, 32'h1);
      chk("R4", "store data old R7", wdata, 32'h0);
      @(posedge clk); #1;
      valid = 1'b0;
      chk(VEC[i][0] ? "R6" : "R1", "abs result", reg_of(i), VEC[i][33:2]);
      chk("R7", "ovf flag", {31'b0, ovf}, {31'b0, VEC[i][0]});
      chk("R10", "store landed", mem[9], 32'h0);
    end

    // R4: store reads R0 while abs writes R0
    @(negedge clk);
    mem[2] = 32'hFFFF_FF00; ovm = 1'b0;
    instr = mk(3'd0, 3'd0, 3'd0, 2'd0, 3'd1, 2'd0);
    valid = 1'b1;
    #1 chk("R4", "same reg store data", wdata, 32'h5);
    @(posedge clk); #1; valid = 1'b0;
    chk("R4", "same reg mem", mem[8], 32'h5);
    chk("R1", "same reg new R0", reg_of(0), 32'h100);

    // R5: load and store both at address 2
    @(negedge clk);
    mem[2] = 32'hFFFF_FFF7;
    instr = mk(3'd2, 3'd1, 3'd0, 2'd0, 3'd0, 2'd0);
    valid = 1'b1;
    @(posedge clk); #1; valid = 1'b0;
    chk("R5", "abs of old word", reg_of(2), 32'h9);
    chk("R5", "stored word", mem[2], 32'h5);

    // R3: index displacements, load AR1+IX0=11, store AR0+IX1=7
    @(negedge clk);
    mem[11] = 32'h0000_0042;
    instr = mk(3'd5, 3'd3, 3'd1, 2'd2, 3'd0, 2'd3);
    valid = 1'b1;
    #1;
    chk("R3", "load addr +ix0", {8'b0, raddr}, 32'd11);
    chk("R3", "store addr +ix1", {8'b0, waddr}, 32'd7);
    @(posedge clk); #1; valid = 1'b0;
    chk("R3", "loaded via ix0", reg_of(5), 32'h42);
    chk("R3", "stored via ix1", mem[7], 32'h7FFF_FFFF);

    // R8: overflow source but valid low, then wrong opcode
    @(negedge clk);
    mem[2] = 32'h8000_0000; ovm = 1'b1;
    instr = mk(3'd6, 3'd0, 3'd0, 2'd0, 3'd1, 2'd0);
    valid = 1'b0;
    #1 chk("R8", "no store when invalid", {31'b0, we}, 32'h0);
    @(posedge clk); #1;
    chk("R8", "reg kept when invalid", reg_of(6), 32'h8000_0000);
    chk("R7", "no ovf when invalid", {31'b0, ovf}, 32'h0);
    @(negedge clk);
    instr[31:26] = 6'b110011; valid = 1'b1;
    #1 chk("R8", "no store bad opcode", {31'b0, we}, 32'h0);
    @(posedge clk); #1; valid = 1'b0;
    chk("R8", "reg kept bad opcode", reg_of(6), 32'h8000_0000);
    chk("R8", "mem kept bad opcode", mem[8], 32'h5);

    // R7: overflow flag clears on following idle cycle
    @(negedge clk);
    instr = mk(3'd6, 3'd0, 3'd0, 2'd0, 3'd1, 2'd0); valid = 1'b1;
    @(posedge clk); #1; valid = 1'b0;
    chk("R7", "ovf raised", {31'b0, ovf}, 32'h1);
    @(posedge clk); #1;
    chk("R7", "ovf one cycle", {31'b0, ovf}, 32'h0);

    // R9: reset mid run
    @(negedge clk);
    instr = mk(3'd6, 3'd0, 3'd0, 2'd0, 3'd1, 2'd0); valid = 1'b1;
    @(posedge clk); #1; valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9", "ovf cleared by reset", {31'b0, ovf}, 32'h0);
    chk("R9", "R0 cleared", reg_of(0), 32'h0);
    chk("R9", "R5 cleared", reg_of(5), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule